// File: doc/BRIEF.md
# Transport Packet Capture DMA Engine

This block sits behind a packet filter and copies whole 188-byte transport packets into a ring-less host buffer. Each packet arrives as 47 consecutive 32-bit words, the first one flagged as start of packet. The words pass straight through to a memory-write port (address, data, valid, ready), and the block generates the address: packet after packet, the words land back to back from a programmable base. The buffer holds `BUF_PKTS` packets (eight by default, 1504 bytes). Once it is full the engine stops writing until software points it at a buffer again.

Software sees two registers. Offset 0x20 holds the buffer base. Writing it rearms the write pointer and clears the packet count. Offset 0x24 is a combined control/status word. It carries the packet count, a packet threshold for the end-of-transfer event, four sticky status flags with their masks, a write-one acknowledge and an active-low run bit that holds the capture logic in reset. A single interrupt line reports the end-of-transfer and overflow flags when they are unmasked.

The capture sequencer has four states:
- `ST_OFF`: run bit clear; nothing is written.
- `ST_IDLE`: waiting for a start-of-packet word.
- `ST_XFER`: writing a packet.
- `ST_DROP`: discarding the rest of a packet.

Its transitions are:
- OFF to IDLE when the run bit is set.
- IDLE to XFER when a start word is accepted and the buffer is not full.
- IDLE to DROP when a start word arrives while the buffer is full.
- XFER to IDLE when the last word is accepted.
- XFER to DROP when the base is rewritten in mid-packet.
- DROP to IDLE when the last word is consumed.
- Any state to OFF when the run bit is cleared.

Top module: `ts_dma_collector`

## Requirements
- R1: After reset the control word at 0x24 reads 0x00027004: count 0, masks at bits 17, 14, 13 and 12 set, run bit 15 clear, threshold 4. The base at 0x20 reads 0, `irq` is low and `mem_valid` is low.
- R2: Words of accepted packets are presented on `mem_addr`/`mem_data` in arrival order. The address is base + 4 per word, and consecutive packets are contiguous. Data is passed unchanged. While a word is being written, `in_ready` equals `mem_ready`.
- R3: Bits 31:24 of 0x24 count completed packets. The count rises by one when the last word of a packet is accepted, and it is cleared by a base write and while the run bit is clear.
- R4: DMA-end status (bit 16) is set in the cycle after the memory port accepts the last word of the packet that brings the count equal to the threshold in bits 6:0. It is not set earlier.
- R5: Once `BUF_PKTS` packets are stored, no further word is written. A start word then sets overflow status (bit 11), and that packet is consumed with `in_ready` high and the count unchanged.
- R6: `irq` is high exactly when DMA-end is set with bit 17 clear, or overflow is set with bit 14 clear. Almost-full and lock status never raise it.
- R7: Writing 0x24 with bit 8 set clears status bits 16, 11, 10 and 9. With bit 8 clear the write leaves them alone. Bit 8 reads 0, and a status event in the same cycle as the acknowledge wins.
- R8: While bit 15 is 0 nothing is written and the pointer returns to the base. After bit 15 is set again, capture resumes at the base with the next start word.
- R9: A base write reloads the pointer with the new base (low two bits forced to 0) and clears the count. A packet in progress has its remaining words discarded.
- R10: Almost-full (bit 10) is set when the count reaches `BUF_PKTS`-1 while bit 13 is clear. Lock (bit 9) is set while `lock_in` is high and bit 12 is clear.
- R11: Words without the start flag that arrive in the idle state are consumed and not written.
- R12: Reads of offsets other than 0x20 and 0x24 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| lock_in | input | 1 | Front-end lock indication |
| in_valid | input | 1 | Input word valid |
| in_sop | input | 1 | Input word is the first of a packet |
| in_data | input | 32 | Input packet word |
| in_ready | output | 1 | Input word consumed this cycle |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory write accepted |
| mem_addr | output | 32 | Memory byte address |
| mem_data | output | 32 | Memory write data |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after several corner cases, each with the failure it would catch:
- Memory stalls on alternate cycles. A design that dropped `in_ready` from the memory handshake would skip or duplicate addresses.
- The exact cycle the DMA-end flag appears. A flag raised on the packet start, or one packet late, would show the wrong count/status word.
- Filling the buffer to its limit and sending one packet more. A design without the full stop would overwrite beyond the buffer, and one without the overflow path would stall the input.
- A mid-packet base rewrite, a mid-packet run-bit clear and stray words without a start flag. Each of these must produce no writes, and the next packet must start exactly at the base.
- An acknowledge arriving while lock is still asserted. This shows that a design letting the acknowledge win over a new event loses that event.

// File: rtl/ts_dma_pkg.sv
package ts_dma_pkg;

    localparam int REG_AW  = 6;
    localparam int CNT_W   = 8;
    localparam int THR_W   = 7;

    localparam logic [REG_AW-1:0] OFF_BASE = 6'h20;
    localparam logic [REG_AW-1:0] OFF_CTRL = 6'h24;

    // control/status bit positions
    localparam int B_CNT_LO = 24;
    localparam int B_MDE    = 17;
    localparam int B_DE     = 16;
    localparam int B_RUN    = 15;
    localparam int B_MOVR   = 14;
    localparam int B_MAF    = 13;
    localparam int B_MLK    = 12;
    localparam int B_OVR    = 11;
    localparam int B_AF     = 10;
    localparam int B_LK     = 9;
    localparam int B_ACK    = 8;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_IDLE,
        ST_XFER,
        ST_DROP
    } cap_state_e;

    typedef struct packed {
        logic de;
        logic ovr;
        logic af;
        logic lk;
    } src_bits_t;

endpackage

// File: rtl/ts_dma_regs.sv
module ts_dma_regs
    import ts_dma_pkg::*;
#(
    parameter int AW       = 32,
    parameter int BUF_PKTS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              lock_in,
    input  logic              pkt_done,
    input  logic [CNT_W-1:0]  done_count,
    input  logic [CNT_W-1:0]  pkt_count,
    input  logic              ovr_evt,
    output logic [AW-1:0]     base_addr,
    output logic [AW-1:0]     load_val,
    output logic              base_load,
    output logic              run,
    output logic              irq,
    output logic              st_de,
    output logic              st_ovr
);

    localparam logic [THR_W-1:0] THR_RST  = THR_W'(BUF_PKTS / 2);
    localparam logic [CNT_W-1:0] AF_LEVEL = CNT_W'(BUF_PKTS - 1);

    src_bits_t        mask_q;
    src_bits_t        stat_q;
    src_bits_t        stat_set;
    logic [THR_W-1:0] thr_q;
    logic             ctrl_we;
    logic             ack;
    logic             unused_wbits;

    assign base_load    = reg_we && (reg_addr == OFF_BASE);
    assign ctrl_we      = reg_we && (reg_addr == OFF_CTRL);
    assign ack          = ctrl_we && reg_wdata[B_ACK];
    assign load_val     = {reg_wdata[AW-1:2], 2'b00};
    assign unused_wbits = ^{reg_wdata[23:18], reg_wdata[7]};

    always_comb begin
        stat_set.de  = pkt_done && (done_count == CNT_W'(thr_q));
        stat_set.ovr = ovr_evt;
        stat_set.af  = pkt_done && (done_count == AF_LEVEL) && !mask_q.af;
        stat_set.lk  = lock_in && !mask_q.lk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr <= '0;
            mask_q    <= '1;
            run       <= 1'b0;
            thr_q     <= THR_RST;
            stat_q    <= '0;
        end else begin
            if (base_load) begin
                base_addr <= load_val;
            end
            if (ctrl_we) begin
                mask_q.de  <= reg_wdata[B_MDE];
                mask_q.ovr <= reg_wdata[B_MOVR];
                mask_q.af  <= reg_wdata[B_MAF];
                mask_q.lk  <= reg_wdata[B_MLK];
                run        <= reg_wdata[B_RUN];
                thr_q      <= reg_wdata[THR_W-1:0];
            end
            stat_q <= (ack ? '0 : stat_q) | stat_set;
        end
    end

    assign st_de  = stat_q.de;
    assign st_ovr = stat_q.ovr;
    assign irq    = (stat_q.de && !mask_q.de) || (stat_q.ovr && !mask_q.ovr);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_BASE: reg_rdata = 32'(base_addr);
            OFF_CTRL: begin
                reg_rdata[31:B_CNT_LO]  = pkt_count;
                reg_rdata[B_MDE]        = mask_q.de;
                reg_rdata[B_DE]         = stat_q.de;
                reg_rdata[B_RUN]        = run;
                reg_rdata[B_MOVR]       = mask_q.ovr;
                reg_rdata[B_MAF]        = mask_q.af;
                reg_rdata[B_MLK]        = mask_q.lk;
                reg_rdata[B_OVR]        = stat_q.ovr;
                reg_rdata[B_AF]         = stat_q.af;
                reg_rdata[B_LK]         = stat_q.lk;
                reg_rdata[THR_W-1:0]    = thr_q;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ts_dma_seq.sv
module ts_dma_seq
    import ts_dma_pkg::*;
#(
    parameter int PKT_WORDS = 47,
    parameter int BUF_PKTS  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             base_load,
    input  logic             in_valid,
    input  logic             in_sop,
    output logic             in_ready,
    input  logic             mem_ready,
    output logic             mem_valid,
    output logic             take,
    output logic             pkt_done,
    output logic             ovr_evt,
    output logic             full,
    output logic [CNT_W-1:0] pkt_count,
    output logic [CNT_W-1:0] done_count
);

    localparam int               WIDX_W   = $clog2(PKT_WORDS);
    localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(PKT_WORDS - 1);
    localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(BUF_PKTS);

    cap_state_e        st, nxt;
    logic [WIDX_W-1:0] widx;
    logic              last;
    logic              wr_sel;
    logic              hs;

    assign last       = (widx == LAST_IDX);
    assign full       = (pkt_count >= FULL_CNT);
    assign done_count = pkt_count + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_OFF;
        end else begin
            st <= nxt;
        end
    end

    // next state and outputs
    always_comb begin
        nxt     = st;
        wr_sel  = 1'b0;
        ovr_evt = 1'b0;
        unique case (st)
            ST_OFF: begin
                nxt = ST_IDLE;
            end
            ST_IDLE: begin
                wr_sel = in_sop && !full;
                if (in_valid && in_sop) begin
                    if (full) begin
                        ovr_evt = run;
                        nxt     = ST_DROP;
                    end else if (mem_ready) begin
                        nxt = ST_XFER;
                    end
                end
            end
            ST_XFER: begin
                wr_sel = 1'b1;
                if (in_valid && mem_ready && last) begin
                    nxt = ST_IDLE;
                end
            end
            ST_DROP: begin
                if (in_valid && last) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_OFF;
        endcase
        if (!run) begin
            nxt = ST_OFF;
        end else if (base_load && (nxt == ST_XFER)) begin
            nxt = ST_DROP;
        end
    end

    assign mem_valid = run && wr_sel && in_valid;
    assign in_ready  = (run && wr_sel) ? mem_ready : 1'b1;
    assign take      = mem_valid && mem_ready;
    assign pkt_done  = take && (st == ST_XFER) && last;
    assign hs        = in_valid && in_ready;

    // word index and packet count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            widx      <= '0;
            pkt_count <= '0;
        end else begin
            if (!run || (st == ST_OFF)) begin
                widx <= '0;
            end else if (hs) begin
                if (st == ST_IDLE) begin
                    widx <= in_sop ? WIDX_W'(1) : '0;
                end else begin
                    widx <= last ? '0 : widx + 1'b1;
                end
            end
            if (!run || base_load) begin
                pkt_count <= '0;
            end else if (pkt_done && !full) begin
                pkt_count <= done_count;
            end
        end
    end

endmodule

// File: rtl/ts_dma_addr.sv
module ts_dma_addr #(
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          hold,
    input  logic [AW-1:0] base_addr,
    input  logic          step,
    output logic [AW-1:0] ptr
);

    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (hold) begin
            ptr <= base_addr;
        end else if (step) begin
            ptr <= ptr + STEP;
        end
    end

endmodule

// File: rtl/ts_dma_collector.sv
module ts_dma_collector
    import ts_dma_pkg::*;
#(
    parameter int AW        = 32,
    parameter int PKT_WORDS = 47,
    parameter int BUF_PKTS  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        lock_in,
    input  logic        in_valid,
    input  logic        in_sop,
    input  logic [31:0] in_data,
    output logic        in_ready,
    output logic        mem_valid,
    input  logic        mem_ready,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_data
    ,
    output logic        irq
);

    logic [AW-1:0]    base_addr;
    logic [AW-1:0]    load_val;
    logic [AW-1:0]    ptr;
    logic             base_load;
    logic             run;
    logic             take;
    logic             pkt_done;
    logic             ovr_evt;
    logic             seq_full;
    logic [CNT_W-1:0] pkt_count;
    logic [CNT_W-1:0] done_count;
    logic             st_de;
    logic             st_ovr;

    ts_dma_regs #(
        .AW       (AW),
        .BUF_PKTS (BUF_PKTS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .lock_in    (lock_in),
        .pkt_done   (pkt_done),
        .done_count (done_count),
        .pkt_count  (pkt_count),
        .ovr_evt    (ovr_evt),
        .base_addr  (base_addr),
        .load_val   (load_val),
        .base_load  (base_load),
        .run        (run),
        .irq        (irq),
        .st_de      (st_de),
        .st_ovr     (st_ovr)
    );

    ts_dma_seq #(
        .PKT_WORDS (PKT_WORDS),
        .BUF_PKTS  (BUF_PKTS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .base_load  (base_load),
        .in_valid   (in_valid),
        .in_sop     (in_sop),
        .in_ready   (in_ready),
        .mem_ready  (mem_ready),
        .mem_valid  (mem_valid),
        .take       (take),
        .pkt_done   (pkt_done),
        .ovr_evt    (ovr_evt),
        .full       (seq_full),
        .pkt_count  (pkt_count),
        .done_count (done_count)
    );

    ts_dma_addr #(
        .AW (AW)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (base_load),
        .load_val  (load_val),
        .hold      (!run),
        .base_addr (base_addr),
        .step      (take),
        .ptr       (ptr)
    );

    assign mem_addr = 32'(ptr);
    assign mem_data = in_data;

endmodule

// File: rtl/ts_dma_collector_chk.sv
module ts_dma_collector_chk #(
    parameter int BUF_PKTS = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [5:0]  reg_addr,
    input logic        ack_bit,
    input logic        in_valid,
    input logic        mem_valid,
    input logic        mem_ready,
    input logic [31:0] mem_addr,
    input logic        irq,
    input logic        full,
    input logic [7:0]  pkt_count,
    input logic        st_de,
    input logic        st_ovr
);

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && !reg_we) |=> (mem_valid |-> (mem_addr == $past(mem_addr) + 32'd4)));

    // R3
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_count <= 8'(BUF_PKTS));

    // R4
    de_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_de) |-> $past(mem_valid && mem_ready));

    // R5
    no_write_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !mem_valid);

    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st_de || st_ovr));

    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_addr == 6'h24) && ack_bit && !in_valid) |=> (!st_de && !st_ovr));

endmodule

bind ts_dma_collector ts_dma_collector_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .ack_bit   (reg_wdata[8]),
    .in_valid  (in_valid),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .irq       (irq),
    .full      (seq_full),
    .pkt_count (pkt_count),
    .st_de     (st_de),
    .st_ovr    (st_ovr)
);

// File: tb/ts_dma_collector_tb.sv
module ts_dma_collector_tb;

    localparam int CLK_PERIOD = 10;

    localparam logic [5:0]  A_BASE = 6'h20;
    localparam logic [5:0]  A_CTRL = 6'h24;
    // run=1 (bit15), lock mask (bit12), threshold 2
    localparam logic [31:0] CTRL_RUN = 32'h0000_9002;
    localparam logic [31:0] ACK      = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lock_in = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;
    logic        irq;

    int          checks = 0;
    int          errors = 0;
    int          ready_mode = 0;
    logic [31:0] exp_ptr = '0;
    logic [31:0] rd;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ts_dma_collector u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .lock_in   (lock_in),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .irq       (irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
        @(posedge clk);
    endtask

    task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send_words(input logic [7:0] tag, input int first, input int n,
                              input bit expect_wr, input string req);
        bit          bad;
        bit          acc;
        logic [31:0] a_act;
        logic [31:0] a_exp;
        int          cyc;
        bad = 0; a_act = '0; a_exp = '0; cyc = 0;
        for (int i = first; i < first + n; i++) begin
            acc = 0;
            while (!acc) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_sop   = (i == 0);
                in_data  = {tag, 24'(i)};
                cyc++;
                mem_ready = (ready_mode == 0) ? 1'b1 : cyc[0];
                #1;
                if (expect_wr) begin
                    if (!mem_valid || (in_ready != mem_ready) ||
                        (in_ready && (mem_addr !== exp_ptr || mem_data !== in_data))) begin
                        if (!bad) begin bad = 1; a_act = mem_addr; a_exp = exp_ptr; end
                    end
                    if (in_ready) exp_ptr += 32'd4;
                end else if (mem_valid || !in_ready) begin
                    if (!bad) begin bad = 1; a_act = {31'b0, mem_valid}; a_exp = '0; end
                end
                acc = in_ready;
                @(posedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; mem_ready = 1'b1;
        chk(!bad, req, a_act, a_exp);
    endtask

    task automatic send_pkt(input logic [7:0] tag, input bit expect_wr, input string req);
        send_words(tag, 0, 47, expect_wr, req);
    endtask

    task automatic t_reset();
        reg_read(A_CTRL, rd);
        chk(rd == 32'h0002_7004, "R1 ctrl", rd, 32'h0002_7004);
        reg_read(A_BASE, rd);
        chk(rd == 32'h0, "R1 base", rd, 32'h0);
        chk(!irq && !mem_valid, "R1 irq/mem_valid", {30'b0, irq, mem_valid}, 32'h0);
    endtask

    task automatic t_basic();
        reg_write(A_BASE, 32'h0000_1003);
        reg_write(A_CTRL, CTRL_RUN);
        exp_ptr = 32'h0000_1000;
        ready_mode = 0;
        send_pkt(8'h10, 1, "R2 first packet");
        reg_read(A_CTRL, rd);
        chk(rd == 32'h0100_9002, "R3/R4 after one packet", rd, 32'h0100_9002);
        ready_mode = 1;
        send_pkt(8'h11, 1, "R2 stalled packet");
        ready_mode = 0;
        reg_read(A_CTRL, rd);
        chk(rd == 32'h0201_9002, "R4 threshold reached", rd, 32'h0201_9002);
        chk(irq == 1'b1, "R6 irq on end event", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_ack();
        reg_write(A_CTRL, CTRL_RUN | 32'h0002_0000);
        reg_read(A_CTRL, rd);
        chk(rd[16] == 1'b1, "R7 no ack keeps status", rd, 32'h0203_9002);
        chk(irq == 1'b0, "R6 masked end event", {31'b0, irq}, 32'h0);
        reg_write(A_CTRL, CTRL_RUN | ACK);
        reg_read(A_CTRL, rd);
        chk(rd == 32'h0200_9002, "R7 ack clears", rd, 32'h0200_9002);
    endtask

    task automatic t_fill();
        for (int p = 2; p < 8; p++) begin
            send_pkt(8'(8'h10 + p), 1, "R2 fill");
            if (p == 6) begin
                reg_read(A_CTRL, rd);
                chk(rd[10] == 1'b1, "R10 almost full", rd, 32'h0700_9402);
            end
        end
        send_pkt(8'h20, 0, "R5 dropped when full");
        reg_read(A_CTRL, rd);
        chk(rd == 32'h0800_9C02, "R5 overflow status", rd, 32'h0800_9C02);
        chk(irq == 1'b1, "R6 irq on overflow", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_rearm();
        reg_write(A_CTRL, CTRL_RUN | ACK);
        reg_read(A_CTRL, rd);
        chk(rd == 32'h0800_9002 && !irq, "R7 ack clears overflow", rd, 32'h0800_9002);
        reg_write(A_BASE, 32'h0000_2000);
        reg_read(A_CTRL, rd);
        chk(rd[31:24] == 8'd0, "R9 base write clears count", rd, 32'h0000_9002);
        exp_ptr = 32'h0000_2000;
        send_pkt(8'h30, 1, "R9 writes resume at new base");
        reg_read(A_CTRL, rd);
        chk(rd[31:24] == 8'd1, "R3 count after rearm", rd, 32'h0100_9002);
    endtask

    task automatic t_softreset();
        send_words(8'h31, 0, 20, 1, "R2 partial packet");
        reg_write(A_CTRL, 32'h0000_1002);
        reg_read(A_CTRL, rd);
        chk(rd[31:24] == 8'd0, "R8 run clear zeroes count", rd, 32'h0000_1002);
        send_pkt(8'h32, 0, "R8 no writes while held");
        reg_write(A_CTRL, CTRL_RUN);
        send_words(8'h33, 5, 5, 0, "R11 stray words discarded");
        exp_ptr = 32'h0000_2000;
        send_pkt(8'h34, 1, "R8 capture restarts at base");
        reg_read(A_CTRL, rd);
        chk(rd[31:24] == 8'd1, "R3 count after restart", rd, 32'h0100_9002);
    endtask

    task automatic t_base_mid();
        send_words(8'h40, 0, 10, 1, "R2 head of packet");
        reg_write(A_BASE, 32'h0000_3000);
        send_words(8'h40, 10, 37, 0, "R9 tail discarded");
        exp_ptr = 32'h0000_3000;
        send_pkt(8'h41, 1, "R9 next packet at new base");
        reg_read(A_CTRL, rd);
        chk(rd[31:24] == 8'd1, "R9 count restarted", rd, 32'h0100_9002);
    endtask

    task automatic t_lock();
        lock_in = 1'b1;
        repeat (2) @(negedge clk);
        reg_read(A_CTRL, rd);
        chk(rd[9] == 1'b0, "R10 lock masked", rd, 32'h0100_9002);
        reg_write(A_CTRL, 32'h0000_8002);
        reg_read(A_CTRL, rd);
        chk(rd[9] == 1'b1, "R10 lock status", rd, 32'h0100_8202);
        chk(irq == 1'b0, "R6 lock never interrupts", {31'b0, irq}, 32'h0);
        reg_write(A_CTRL, 32'h0000_8102);
        reg_read(A_CTRL, rd);
        chk(rd[9] == 1'b1 && rd[8] == 1'b0, "R7 event beats ack", rd, 32'h0100_8202);
        lock_in = 1'b0;
        reg_write(A_CTRL, 32'h0000_8102);
        reg_read(A_CTRL, rd);
        chk(rd[9] == 1'b0, "R7 ack clears lock", rd, 32'h0100_8002);
    endtask

    task automatic t_unmapped();
        reg_read(6'h10, rd);
        chk(rd == 32'h0, "R12 unmapped read", rd, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_ack();
        t_fill();
        t_rearm();
        t_softreset();
        t_base_mid();
        t_lock();
        t_unmapped();
        finish_run();
    end

endmodule